// File: doc/BRIEF.md
# Two-Digit Adaptive Delta Modulation Encoder

This block turns a stream of signed fixed-point samples into adaptive delta modulation codewords. Each accepted sample yields one codeword of two digits. The first digit is binary and gives the sign of the prediction error. The second digit is ternary and tells whether the step grew, held or shrank relative to a sign-memory factor. The encoder holds its own reconstruction of the signal, which is also driven out so that a matching decoder, or a bench, can compare against it.

Each sample passes through a three-state controller. ST_IDLE waits for `in_valid` and captures the sample, then moves to ST_MEASURE. ST_MEASURE forms the error against the stored prediction. It picks the memory factor from the current and previous sign digits, scales the previous step, and compares the error magnitude with two thresholds derived from that scaled step. It then moves to ST_COMMIT. ST_COMMIT applies one of six overall multipliers to the step, clamps the result, moves the prediction by the new step in the direction of the sign digit, and emits the codeword. It then returns to ST_IDLE. A sample is taken only in ST_IDLE.

All constants are unsigned Q4.12 parameters. Every product rounds as round(a*b) = (a*b + 2048) >> 12. The defaults are α = 1.1 (4506), 1/α (3724), β = 2.2 (9011), 1/β (1862), the upper threshold factor (β+1)/2 (6554) and the lower threshold factor (1/β+1)/2 (2979). The step runs from 256 within a ±20 dB window [26, 2560].

Top module: `adm2_encoder`

## Requirements
- R1: A synchronous reset sets `out_valid`, `out_sign_neg`, `out_mag` and `out_recon` to zero, the prediction to 0, the step to INIT_STEP (256) and the stored previous sign digit to +1.
- R2: The error is the captured sample minus the prediction held from the previous sample. The sign digit is +1 (`out_sign_neg` = 0) when the error is zero or positive, and −1 (`out_sign_neg` = 1) when it is negative.
- R3: The scaled step is nd = round(F * step), where F is α (4506) if the sign digit equals the previous sample's sign digit and 1/α (3724) if it differs.
- R4: With hi = round(6554 * nd) and lo = round(2979 * nd), `out_mag` is 01 (+1) when |error| ≥ hi, 11 (−1) when |error| ≤ lo, and 00 (0) otherwise. The code 10 never appears.
- R5: The new step is round(9011 * nd) for code 01, round(1862 * nd) for code 11, or nd for code 00. It is saturated to SW bits and then clamped to [STEP_MIN, STEP_MAX] (26, 2560).
- R6: The new prediction is the old one plus the new step for sign +1, or minus it for sign −1. It saturates to the signed DW-bit range [−32768, 32767] and is driven on `out_recon`.
- R7: `out_valid` is high for exactly one cycle. The codeword and `out_recon` change on the second rising edge after the edge that accepted the sample, and hold otherwise.
- R8: `in_valid` seen while a sample is in ST_MEASURE or ST_COMMIT is ignored. It produces no codeword and does not alter the result of the sample in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, taken in ST_IDLE only |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle codeword strobe |
| out_sign_neg | output | 1 | Sign digit, 1 means −1 |
| out_mag | output | 2 | Ternary digit: 01 = +1, 00 = 0, 11 = −1 |
| out_recon | output | DW | Signed reconstructed prediction |

## Verification
A sample accepted on rising edge k produces nothing at edge k+1. The codeword, the strobe and the new reconstruction all appear at edge k+2, and the strobe clears at k+3. The bench drives inputs on falling edges. At the falling edge after k+1 it checks that the strobe is still low. At the falling edge after k+2 it compares all outputs against an arithmetic model built from the requirements. For the ignored-strobe case it holds `in_valid` through both busy states, then watches three more cycles to confirm that no second strobe appears.

// File: rtl/adm_pkg.sv
package adm_pkg;

    localparam int QF = 12;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_COMMIT  = 2'd2
    } adm_state_t;

    localparam logic [1:0] MAG_UP   = 2'b01;
    localparam logic [1:0] MAG_HOLD = 2'b00;
    localparam logic [1:0] MAG_DOWN = 2'b11;

    // Q4.12 product with round-half-up
    function automatic logic [31:0] qmul(input logic [31:0] a, input logic [15:0] q);
        logic [47:0] p;
        p = {16'b0, a} * {32'b0, q} + (48'd1 << (QF - 1));
        return 32'(p >> QF);
    endfunction

endpackage

// File: rtl/adm_threshold.sv
module adm_threshold
    import adm_pkg::*;
#(
    parameter int SW          = 16,
    parameter int MW          = 17,
    parameter int ALPHA_Q     = 4506,
    parameter int INV_ALPHA_Q = 3724,
    parameter int HI_Q        = 6554,
    parameter int LO_Q        = 2979
) (
    input  logic [SW-1:0] step,
    input  logic          same_sign,
    input  logic [MW-1:0] mag,
    output logic [31:0]   nd,
    output logic [1:0]    code
);
    logic [31:0] hi_lim;
    logic [31:0] lo_lim;
    logic [31:0] mag32;

    always_comb begin
        nd     = qmul(32'(step), same_sign ? 16'(ALPHA_Q) : 16'(INV_ALPHA_Q));
        hi_lim = qmul(nd, 16'(HI_Q));
        lo_lim = qmul(nd, 16'(LO_Q));
        mag32  = 32'(mag);
        if (mag32 >= hi_lim)
            code = MAG_UP;
        else if (mag32 <= lo_lim)
            code = MAG_DOWN;
        else
            code = MAG_HOLD;
    end
endmodule

// File: rtl/adm_step_update.sv
module adm_step_update
    import adm_pkg::*;
#(
    parameter int SW         = 16,
    parameter int STEP_MIN   = 26,
    parameter int STEP_MAX   = 2560,
    parameter int BETA_Q     = 9011,
    parameter int INV_BETA_Q = 1862
) (
    input  logic [31:0]   nd,
    input  logic [1:0]    code,
    output logic [SW-1:0] step_next
);
    localparam logic [31:0] SAT_LIM = 32'((64'd1 << SW) - 64'd1);
    localparam logic [31:0] MIN_LIM = 32'(STEP_MIN);
    localparam logic [31:0] MAX_LIM = 32'(STEP_MAX);

    logic [31:0] scaled;
    logic [31:0] sat;
    logic [31:0] clamped;

    always_comb begin
        unique case (code)
            MAG_UP:   scaled = qmul(nd, 16'(BETA_Q));
            MAG_DOWN: scaled = qmul(nd, 16'(INV_BETA_Q));
            default:  scaled = nd;
        endcase
        sat = (scaled > SAT_LIM) ? SAT_LIM : scaled;
        if (sat < MIN_LIM)
            clamped = MIN_LIM;
        else if (sat > MAX_LIM)
            clamped = MAX_LIM;
        else
            clamped = sat;
        step_next = SW'(clamped);
    end
endmodule

// File: rtl/adm_predict.sv
module adm_predict #(
    parameter int DW = 16,
    parameter int SW = 16
) (
    input  logic signed [DW-1:0] y_old,
    input  logic [SW-1:0]        step,
    input  logic                 neg,
    output logic signed [DW-1:0] y_new
);
    localparam int SUMW = ((DW > SW) ? DW : SW) + 2;
    localparam logic signed [SUMW-1:0] Y_HI =
        $signed({{(SUMW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [SUMW-1:0] Y_LO =
        $signed({{(SUMW-DW+1){1'b1}}, {(DW-1){1'b0}}});

    logic signed [SUMW-1:0] y_ext;
    logic signed [SUMW-1:0] st_ext;
    logic signed [SUMW-1:0] sum;

    always_comb begin
        y_ext  = $signed({{(SUMW-DW){y_old[DW-1]}}, y_old});
        st_ext = $signed({{(SUMW-SW){1'b0}}, step});
        sum    = neg ? (y_ext - st_ext) : (y_ext + st_ext);
        if (sum > Y_HI)
            y_new = Y_HI[DW-1:0];
        else if (sum < Y_LO)
            y_new = Y_LO[DW-1:0];
        else
            y_new = sum[DW-1:0];
    end
endmodule

// File: rtl/adm2_encoder.sv
module adm2_encoder
    import adm_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SW          = 16,
    parameter int INIT_STEP   = 256,
    parameter int STEP_MIN    = 26,
    parameter int STEP_MAX    = 2560,
    parameter int ALPHA_Q     = 4506,
    parameter int INV_ALPHA_Q = 3724,
    parameter int BETA_Q      = 9011,
    parameter int INV_BETA_Q  = 1862,
    parameter int HI_Q        = 6554,
    parameter int LO_Q        = 2979
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 out_valid,
    output logic                 out_sign_neg,
    output logic [1:0]           out_mag,
    output logic signed [DW-1:0] out_recon
);
    localparam int MW = DW + 1;

    adm_state_t state, state_nx;

    logic signed [DW-1:0] x_q;
    logic signed [DW-1:0] y_q;
    logic [SW-1:0]        step_q;
    logic                 prev_neg;
    logic                 meas_neg;
    logic [1:0]           meas_code;
    logic [31:0]          meas_nd;

    logic signed [DW:0]   err;
    logic                 err_neg;
    logic [MW-1:0]        err_mag;
    logic [31:0]          nd_c;
    logic [1:0]           code_c;
    logic [SW-1:0]        step_nx;
    logic signed [DW-1:0] y_nx;

    // error against the prediction left by the previous sample
    always_comb begin
        err     = $signed({x_q[DW-1], x_q}) - $signed({y_q[DW-1], y_q});
        err_neg = err[DW];
        err_mag = err_neg ? MW'(-err) : MW'(err);
    end

    adm_threshold #(
        .SW(SW), .MW(MW), .ALPHA_Q(ALPHA_Q), .INV_ALPHA_Q(INV_ALPHA_Q),
        .HI_Q(HI_Q), .LO_Q(LO_Q)
    ) u_thresh (
        .step(step_q), .same_sign(err_neg == prev_neg), .mag(err_mag),
        .nd(nd_c), .code(code_c)
    );

    adm_step_update #(
        .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
        .BETA_Q(BETA_Q), .INV_BETA_Q(INV_BETA_Q)
    ) u_step (
        .nd(meas_nd), .code(meas_code), .step_next(step_nx)
    );

    adm_predict #(.DW(DW), .SW(SW)) u_pred (
        .y_old(y_q), .step(step_nx), .neg(meas_neg), .y_new(y_nx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (in_valid) state_nx = ST_MEASURE;
            ST_MEASURE: state_nx = ST_COMMIT;
            ST_COMMIT:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q       <= '0;
            y_q       <= '0;
            step_q    <= SW'(INIT_STEP);
            prev_neg  <= 1'b0;
            meas_neg  <= 1'b0;
            meas_code <= MAG_HOLD;
            meas_nd   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) x_q <= in_sample;
                ST_MEASURE: begin
                    meas_neg  <= err_neg;
                    meas_code <= code_c;
                    meas_nd   <= nd_c;
                end
                ST_COMMIT: begin
                    step_q   <= step_nx;
                    y_q      <= y_nx;
                    prev_neg <= meas_neg;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_sign_neg <= 1'b0;
            out_mag      <= MAG_HOLD;
            out_recon    <= '0;
        end else begin
            out_valid <= (state == ST_COMMIT);
            if (state == ST_COMMIT) begin
                out_sign_neg <= meas_neg;
                out_mag      <= meas_code;
                out_recon    <= y_nx;
            end
        end
    end
endmodule

// File: rtl/adm2_checker.sv
module adm2_checker #(
    parameter int DW       = 16,
    parameter int SW       = 16,
    parameter int STEP_MIN = 26,
    parameter int STEP_MAX = 2560
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 out_valid,
    input logic                 out_sign_neg,
    input logic [1:0]           out_mag,
    input logic signed [DW-1:0] out_recon,
    input logic [SW-1:0]        step_q
);
    assert_code_legal_R4: assert property (@(posedge clk) disable iff (rst)
        out_mag != 2'b10);

    assert_step_window_R5: assert property (@(posedge clk) disable iff (rst)
        (32'(step_q) >= 32'(STEP_MIN)) && (32'(step_q) <= 32'(STEP_MAX)));

    assert_up_direction_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sign_neg) |-> (out_recon >= $past(out_recon)));

    assert_down_direction_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sign_neg) |-> (out_recon <= $past(out_recon)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_recon) && $stable(out_mag) && $stable(out_sign_neg)));
endmodule

bind adm2_encoder adm2_checker #(
    .DW(DW), .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
) u_adm2_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_sign_neg(out_sign_neg),
    .out_mag(out_mag), .out_recon(out_recon), .step_q(step_q)
);

// File: tb/tb_adm2_encoder.sv
module tb_adm2_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int NSTIM = 12;
    localparam int STIM [0:NSTIM-1] = '{500, 480, -200, -2000, 3000, 3100,
                                        3050, 100, -5000, -4990, 0, 7};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic               out_sign_neg;
    logic [1:0]         out_mag;
    logic signed [15:0] out_recon;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint m_y, m_step;
    bit     m_prev_neg;
    bit     e_neg;
    logic [1:0] e_code;
    longint e_y;

    always #(CLK_PERIOD/2) clk = ~clk;

    adm2_encoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sign_neg(out_sign_neg),
        .out_mag(out_mag), .out_recon(out_recon)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint rnd(input longint a, input longint q);
        return (a * q + 2048) >>> 12;
    endfunction

    // arithmetic model written from R2..R6
    task automatic model(input longint x);
        longint e, mag, nd, hi, lo, ns;
        e = x - m_y;
        e_neg = (e < 0);
        mag = e_neg ? -e : e;
        nd = rnd(m_step, (e_neg == m_prev_neg) ? 4506 : 3724);
        hi = rnd(nd, 6554);
        lo = rnd(nd, 2979);
        if (mag >= hi) begin e_code = 2'b01; ns = rnd(nd, 9011); end
        else if (mag <= lo) begin e_code = 2'b11; ns = rnd(nd, 1862); end
        else begin e_code = 2'b00; ns = nd; end
        if (ns > 65535) ns = 65535;
        if (ns < 26) ns = 26;
        if (ns > 2560) ns = 2560;
        m_y = e_neg ? m_y - ns : m_y + ns;
        if (m_y > 32767) m_y = 32767;
        if (m_y < -32768) m_y = -32768;
        m_step = ns;
        m_prev_neg = e_neg;
        e_y = m_y;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_y = 0; m_step = 256; m_prev_neg = 1'b0;
    endtask

    // accept on edge k; outputs land on edge k+2
    task automatic send(input longint x, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 strobe low one cycle after accept", longint'(out_valid), 0);
        @(negedge clk);
        model(x);
        chk("R7 strobe at second edge", longint'(out_valid), 1);
        chk({req, " sign"}, longint'(out_sign_neg), longint'(e_neg));
        chk({req, " mag code"}, longint'(out_mag), longint'(e_code));
        chk({req, " recon"}, longint'(out_recon), e_y);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        longint prev_r;
        do_reset();
        @(negedge clk);
        chk("R1 reset out_valid", longint'(out_valid), 0);
        chk("R1 reset sign", longint'(out_sign_neg), 0);
        chk("R1 reset mag", longint'(out_mag), 0);
        chk("R1 reset recon", longint'(out_recon), 0);

        // R1 initial step and +1 memory; R4 middle band gives 00
        send(300, "R4 hold band");
        chk("R4 hold literal recon", longint'(out_recon), 282);
        chk("R4 hold literal code", longint'(out_mag), 0);

        do_reset();
        send(1000, "R4 up");
        chk("R5 up literal recon", longint'(out_recon), 620);
        chk("R4 up literal code", longint'(out_mag), 1);
        send(620, "R2 zero error");
        chk("R2 zero error is positive", longint'(out_sign_neg), 0);
        chk("R4 down literal code", longint'(out_mag), 3);
        chk("R6 literal recon", longint'(out_recon), 930);

        do_reset();
        send(-1000, "R3 sign change");
        chk("R3 sign change literal recon", longint'(out_recon), -513);
        chk("R2 negative sign literal", longint'(out_sign_neg), 1);

        // table walk from current state
        for (int i = 0; i < NSTIM; i++) send(longint'(STIM[i]), "R3 table");

        // R5 upper clamp, then R6 saturation
        do_reset();
        prev_r = 0;
        for (int i = 0; i < 18; i++) begin
            send(32767, "R5 climb");
            if (i == 4) chk("R5 step clamps at max", longint'(out_recon) - prev_r, 2560);
            prev_r = longint'(out_recon);
        end
        chk("R6 saturates at top", longint'(out_recon), 32767);

        // R5 lower clamp: track the prediction so error is zero
        do_reset();
        prev_r = 0;
        for (int i = 0; i < 8; i++) begin
            prev_r = m_y;
            send(m_y, "R5 decay");
        end
        chk("R5 step clamps at min", longint'(out_recon) - prev_r, 26);

        // R8 strobe held through busy states is ignored
        do_reset();
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'sd1000;
        @(negedge clk);
        in_sample = -16'sd3000;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model(1000);
        chk("R8 in-flight result valid", longint'(out_valid), 1);
        chk("R8 in-flight result recon", longint'(out_recon), 620);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 no extra codeword", longint'(out_valid), 0);
        end
        chk("R8 recon unchanged", longint'(out_recon), 620);
        send(620, "R8 state after ignore");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule